// File: doc/BRIEF.md
# Packet Router Acceptance Controller

This block sequences how a one-input, three-output byte router accepts one packet. A packet arrives as a header byte, then 1 to 63 payload bytes, then a parity byte. The header carries the destination port in its two low bits. The controller watches the source's packet-active flag, the destination address and the status of the selected output buffer. It raises one strobe per phase to tell the datapath what to latch, and it raises a write request when a byte should go into the buffer. It also holds the source back whenever it cannot take a new byte. At the end of each packet it pulses a clear for the datapath's status registers.

If the buffer fills while a packet is arriving, the controller parks in a stall phase. Once space returns it resumes through a reload phase. That phase uses two sticky flags from the datapath to choose where to go next: whether the parity byte has already been taken, and whether the source has already ended the payload. All outputs are decoded from the current state alone. Each strobe therefore lasts exactly as many cycles as the controller spends in its phase. The state register can be binary or one-hot coded, chosen by a parameter.

Top module: `rtr_pkt_ctrl`

## Requirements
- R1: Reset is active-low and synchronous. After any clock edge that samples rst_n low, the controller is in the idle/decode phase: hdr_strobe is 1 and every other output is 0.
- R2: In the decode phase, with pkt_active high and dest_addr below NUM_PORTS (0, 1 or 2 by default), the next phase is first-byte load if sel_empty is 1, and wait-for-empty otherwise.
- R3: In the decode phase, an address of NUM_PORTS or above (3 by default) or pkt_active low keeps the controller in the decode phase. No packet is started.
- R4: The first-byte phase raises first_ld and src_hold with wr_req low. It lasts exactly one cycle and is always followed by the payload phase.
- R5: The payload phase raises body_ld and wr_req with src_hold low. sel_full high moves it to stall, and this takes priority. Otherwise pkt_active low moves it to the parity phase. Otherwise it stays.
- R6: The parity phase raises par_ld, wr_req and src_hold. It moves to stall if sel_full is high, and to the check phase otherwise.
- R7: The stall phase raises stall_st and src_hold with wr_req low. It stays while sel_full is high and moves to the resume phase on the first cycle sel_full is low.
- R8: The resume phase raises resume_ld, wr_req and src_hold. Its next phase is chosen in this order: check if par_seen is 1, else parity if valid_dropped is 1, else payload.
- R9: The wait-for-empty phase raises only src_hold. It moves to first-byte load when sel_empty is 1.
- R10: The check phase raises clr_status and src_hold for exactly one cycle and then returns to the decode phase.
- R11: In every cycle at most one of the seven phase strobes (hdr_strobe, first_ld, body_ld, par_ld, stall_st, resume_ld, clr_status) is high. In the wait phase, none of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_active | input | 1 | Source marks header and payload bytes |
| dest_addr | input | ADDR_W | Destination field of the header byte |
| sel_full | input | 1 | Selected output buffer is full |
| sel_empty | input | 1 | Selected output buffer is empty |
| par_seen | input | 1 | Sticky: parity byte already taken |
| valid_dropped | input | 1 | Sticky: source ended the payload |
| hdr_strobe | output | 1 | Decode phase: capture header, pick port |
| first_ld | output | 1 | Move the held header toward the buffer |
| body_ld | output | 1 | Payload byte load |
| par_ld | output | 1 | Parity byte load |
| stall_st | output | 1 | Buffer-full stall |
| resume_ld | output | 1 | Reload of the byte held during a stall |
| wr_req | output | 1 | Write request to the selected buffer |
| src_hold | output | 1 | Back-pressure to the packet source |
| clr_status | output | 1 | Clear datapath status and parity registers |

## Verification
Every output is a pure decode of the state register, so the effect of the inputs sampled at one rising edge shows up on the outputs right after that edge and stays until the next one. The bench drives inputs at the falling edge and holds them across the following rising edge. At the next falling edge it first advances its own phase model by one step using the held inputs, and then compares all nine outputs before it drives fresh values. In this way each transition, including a reset edge, is checked in exactly the cycle it becomes visible, and the strobe-exclusivity check runs on the same samples.

// File: rtl/rtr_ctrl_pkg.sv
package rtr_ctrl_pkg;

   localparam int unsigned NUM_STATES = 8;
   localparam int unsigned STATE_W    = $clog2(NUM_STATES);

   // Phase encoding; the one-hot variant uses the value as the bit index.
   typedef enum logic [STATE_W-1:0] {
      ST_DECODE = 3'd0,
      ST_FIRST  = 3'd1,
      ST_BODY   = 3'd2,
      ST_PARITY = 3'd3,
      ST_STALL  = 3'd4,
      ST_RESUME = 3'd5,
      ST_WAIT   = 3'd6,
      ST_CHECK  = 3'd7
   } ctrl_state_e;

   typedef struct packed {
      logic hdr;
      logic first;
      logic body;
      logic par;
      logic stall;
      logic resume;
      logic clr;
      logic wr;
      logic hold;
   } ctrl_out_s;

   localparam int CODING_BINARY = 0;
   localparam int CODING_ONEHOT = 1;

endpackage

// File: rtl/rtr_ctrl_next.sv
module rtr_ctrl_next
   import rtr_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int NUM_PORTS = 3
) (
   input  ctrl_state_e       cur,
   input  logic              pkt_active,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic              sel_full,
   input  logic              sel_empty,
   input  logic              par_seen,
   input  logic              valid_dropped,
   output ctrl_state_e       nxt
);

   localparam logic [ADDR_W:0] PORT_LIMIT = NUM_PORTS[ADDR_W:0];

   logic addr_ok;
   assign addr_ok = ({1'b0, dest_addr} < PORT_LIMIT);

   always_comb begin
      nxt = cur;
      unique case (cur)
         ST_DECODE: begin
            if (pkt_active && addr_ok)
               nxt = sel_empty ? ST_FIRST : ST_WAIT;
         end
         ST_FIRST:  nxt = ST_BODY;
         ST_BODY: begin
            if (sel_full)         nxt = ST_STALL;
            else if (!pkt_active) nxt = ST_PARITY;
         end
         ST_PARITY: nxt = sel_full ? ST_STALL : ST_CHECK;
         ST_STALL: begin
            if (!sel_full) nxt = ST_RESUME;
         end
         ST_RESUME: begin
            if (par_seen)           nxt = ST_CHECK;
            else if (valid_dropped) nxt = ST_PARITY;
            else                    nxt = ST_BODY;
         end
         ST_WAIT: begin
            if (sel_empty) nxt = ST_FIRST;
         end
         ST_CHECK:  nxt = ST_DECODE;
         default:   nxt = ST_DECODE;
      endcase
   end

endmodule

// File: rtl/rtr_ctrl_state_reg.sv
module rtr_ctrl_state_reg
   import rtr_ctrl_pkg::*;
#(
   parameter int STATE_CODING = CODING_BINARY
) (
   input  logic        clk,
   input  logic        rst_n,
   input  ctrl_state_e nxt,
   output ctrl_state_e cur
);

   generate
      if (STATE_CODING == CODING_ONEHOT) begin : g_onehot
         localparam logic [NUM_STATES-1:0] HOT_ONE = {{(NUM_STATES-1){1'b0}}, 1'b1};
         logic [NUM_STATES-1:0] hot_q;

         always_ff @(posedge clk) begin
            if (!rst_n) hot_q <= HOT_ONE << ST_DECODE;
            else        hot_q <= HOT_ONE << nxt;
         end

         always_comb begin
            cur = ST_DECODE;
            for (int i = 0; i < NUM_STATES; i++)
               if (hot_q[i]) cur = ctrl_state_e'(STATE_W'(i));
         end

         // R11: exactly one phase bit is live once reset is released
         p_hot_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(hot_q));
      end else begin : g_binary
         ctrl_state_e bin_q;

         always_ff @(posedge clk) begin
            if (!rst_n) bin_q <= ST_DECODE;
            else        bin_q <= nxt;
         end

         assign cur = bin_q;
      end
   endgenerate

endmodule

// File: rtl/rtr_ctrl_out_dec.sv
module rtr_ctrl_out_dec
   import rtr_ctrl_pkg::*;
(
   input  ctrl_state_e cur,
   output ctrl_out_s   o
);

   always_comb begin
      o = '0;
      unique case (cur)
         ST_DECODE: o.hdr = 1'b1;
         ST_FIRST:  begin o.first = 1'b1;  o.hold = 1'b1; end
         ST_BODY:   begin o.body = 1'b1;   o.wr = 1'b1; end
         ST_PARITY: begin o.par = 1'b1;    o.wr = 1'b1; o.hold = 1'b1; end
         ST_STALL:  begin o.stall = 1'b1;  o.hold = 1'b1; end
         ST_RESUME: begin o.resume = 1'b1; o.wr = 1'b1; o.hold = 1'b1; end
         ST_WAIT:   o.hold = 1'b1;
         ST_CHECK:  begin o.clr = 1'b1;    o.hold = 1'b1; end
         default:   o.hdr = 1'b1;
      endcase
   end

endmodule

// File: rtl/rtr_pkt_ctrl.sv
module rtr_pkt_ctrl
   import rtr_ctrl_pkg::*;
#(
   parameter int ADDR_W       = 2,
   parameter int NUM_PORTS    = 3,
   parameter int STATE_CODING = CODING_BINARY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_active,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic              sel_full,
   input  logic              sel_empty,
   input  logic              par_seen,
   input  logic              valid_dropped,
   output logic              hdr_strobe,
   output logic              first_ld,
   output logic              body_ld,
   output logic              par_ld,
   output logic              stall_st,
   output logic              resume_ld,
   output logic              wr_req,
   output logic              src_hold,
   output logic              clr_status
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
         $error("rtr_pkt_ctrl: ADDR_W must be 1..8");
      end
      if (NUM_PORTS < 1 || NUM_PORTS > ADDR_SPAN) begin : g_bad_ports
         $error("rtr_pkt_ctrl: NUM_PORTS must fit in the address field");
      end
      if (STATE_CODING != CODING_BINARY && STATE_CODING != CODING_ONEHOT) begin : g_bad_coding
         $error("rtr_pkt_ctrl: unknown STATE_CODING");
      end
   endgenerate

   ctrl_state_e cur_st, nxt_st;
   ctrl_out_s   dec;

   rtr_ctrl_next #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_next (
      .cur(cur_st), .pkt_active(pkt_active), .dest_addr(dest_addr),
      .sel_full(sel_full), .sel_empty(sel_empty), .par_seen(par_seen),
      .valid_dropped(valid_dropped), .nxt(nxt_st)
   );

   rtr_ctrl_state_reg #(.STATE_CODING(STATE_CODING)) u_state (
      .clk(clk), .rst_n(rst_n), .nxt(nxt_st), .cur(cur_st)
   );

   rtr_ctrl_out_dec u_dec (.cur(cur_st), .o(dec));

   assign hdr_strobe = dec.hdr;
   assign first_ld   = dec.first;
   assign body_ld    = dec.body;
   assign par_ld     = dec.par;
   assign stall_st   = dec.stall;
   assign resume_ld  = dec.resume;
   assign wr_req     = dec.wr;
   assign src_hold   = dec.hold;
   assign clr_status = dec.clr;

   localparam logic [ADDR_W:0] PORT_LIMIT = NUM_PORTS[ADDR_W:0];

   // R3: an out-of-range address never leaves the decode phase
   p_bad_addr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_strobe && ({1'b0, dest_addr} >= PORT_LIMIT) |=> hdr_strobe);

   // R4: first-byte phase always hands over to payload
   p_first_then_body_r4: assert property (@(posedge clk) disable iff (!rst_n)
      first_ld |=> body_ld);

   // R5: buffer full during payload stalls the packet
   p_body_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      body_ld && sel_full |=> stall_st);

   // R7: stall holds while full and resumes once space returns
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_st && sel_full |=> stall_st);
   p_stall_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall_st && !sel_full |=> resume_ld);

   // R8: sticky parity flag wins in the resume phase
   p_resume_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_ld && par_seen |=> clr_status);

   // R10: check phase lasts one cycle and returns to decode
   p_check_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_status |=> hdr_strobe);

   // R11: phase strobes are mutually exclusive
   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hdr_strobe, first_ld, body_ld, par_ld, stall_st, resume_ld, clr_status}));

endmodule

// File: tb/test_rtr_pkt_ctrl.sv
module test_rtr_pkt_ctrl;

   localparam int  ADDR_W = 2;
   localparam int  PORTS  = 3;
   localparam int  RUN_CYCLES = 6000;

   // reference phase codes (bench-local)
   localparam int M_IDLE = 0, M_FIRST = 1, M_BODY = 2, M_PAR = 3,
                  M_STALL = 4, M_RES = 5, M_WAIT = 6, M_CHK = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pkt_active = 1'b0;
   logic [ADDR_W-1:0] dest_addr = '0;
   logic sel_full = 1'b0, sel_empty = 1'b0, par_seen = 1'b0, valid_dropped = 1'b0;
   logic hdr_strobe, first_ld, body_ld, par_ld, stall_st, resume_ld, wr_req, src_hold, clr_status;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   rtr_pkt_ctrl #(.ADDR_W(ADDR_W), .NUM_PORTS(PORTS)) i_rtr_pkt_ctrl (
      .clk(clk), .rst_n(rst_n), .pkt_active(pkt_active), .dest_addr(dest_addr),
      .sel_full(sel_full), .sel_empty(sel_empty), .par_seen(par_seen),
      .valid_dropped(valid_dropped), .hdr_strobe(hdr_strobe), .first_ld(first_ld),
      .body_ld(body_ld), .par_ld(par_ld), .stall_st(stall_st), .resume_ld(resume_ld),
      .wr_req(wr_req), .src_hold(src_hold), .clr_status(clr_status)
   );

   // expected {hdr,first,body,par,stall,resume,clr,wr,hold}
   function automatic logic [8:0] expect_out(int s);
      case (s)
         M_IDLE:  return 9'b1_000000_0_0;
         M_FIRST: return 9'b0_100000_0_1;
         M_BODY:  return 9'b0_010000_1_0;
         M_PAR:   return 9'b0_001000_1_1;
         M_STALL: return 9'b0_000100_0_1;
         M_RES:   return 9'b0_000010_1_1;
         M_WAIT:  return 9'b0_000000_0_1;
         default: return 9'b0_000001_0_1;
      endcase
   endfunction

   function automatic string req_tag(int prev, bit was_reset, bit bad_addr);
      if (was_reset) return "R1";
      case (prev)
         M_IDLE:  return bad_addr ? "R3" : "R2";
         M_FIRST: return "R4";
         M_BODY:  return "R5";
         M_PAR:   return "R6";
         M_STALL: return "R7";
         M_RES:   return "R8";
         M_WAIT:  return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic int step(int s, bit r, bit act, int addr, bit full, bit empty,
                               bit seen, bit dropped);
      if (!r) return M_IDLE;
      if (s == M_IDLE) begin
         if (!act || addr >= PORTS) return M_IDLE;
         return empty ? M_FIRST : M_WAIT;
      end
      if (s == M_FIRST) return M_BODY;
      if (s == M_BODY)  return full ? M_STALL : (!act ? M_PAR : M_BODY);
      if (s == M_PAR)   return full ? M_STALL : M_CHK;
      if (s == M_STALL) return full ? M_STALL : M_RES;
      if (s == M_RES)   return seen ? M_CHK : (dropped ? M_PAR : M_BODY);
      if (s == M_WAIT)  return empty ? M_FIRST : M_WAIT;
      return M_IDLE;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      int model = M_IDLE;
      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
         @(negedge clk);
         begin
            int prev = model;
            bit bad = (int'(dest_addr) >= PORTS) && pkt_active;
            logic [8:0] got, exp;
            model = step(model, rst_n, pkt_active, int'(dest_addr), sel_full, sel_empty,
                         par_seen, valid_dropped);
            got = {hdr_strobe, first_ld, body_ld, par_ld, stall_st, resume_ld, clr_status,
                   wr_req, src_hold};
            exp = expect_out(model);
            n_cmp++;
            if (got !== exp) begin
               n_bad++;
               $display("FAIL %s cycle %0d: got %b expected %b",
                        req_tag(prev, !rst_n, bad), cyc, got, exp);
            end
            // R11: strobe exclusivity, none in the wait phase
            n_cmp++;
            if ($countones(got[8:2]) > (model == M_WAIT ? 0 : 1) ||
                (model != M_WAIT && $countones(got[8:2]) != 1)) begin
               n_bad++;
               $display("FAIL R11 cycle %0d: got strobes %b expected one-hot (wait: none)",
                        cyc, got[8:2]);
            end
         end
         // drive next inputs
         rst_n         <= (cyc < 3) ? 1'b0 : (($urandom % 300) != 0);
         pkt_active    <= (($urandom % 5) != 0);
         dest_addr     <= ADDR_W'($urandom % 4);
         sel_full      <= (($urandom % 4) == 0);
         sel_empty     <= (($urandom % 2) == 0);
         par_seen      <= (($urandom % 3) == 0);
         valid_dropped <= (($urandom % 3) == 0);
      end
      finished = 1'b1;
      summary();
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
      end
   end

endmodule